// File: doc/BRIEF.md
# Configurable Synchronous Serial Shift Engine

This block moves one byte at a time over a three-line synchronous serial link (clock, data out, data in) framed by an active-low chip select. As clock master it generates the serial clock from the system clock at one of seven divider rates and drives its own chip-select output. As clock slave it takes the serial clock and chip select from outside and brings them into the system clock domain before using them.

Control inputs choose the clock idle level, which edge launches data and which captures it, and whether bits leave least or most significant first. A second mode, clock-synchronous mode, forces phase-0 timing whatever the phase input says, while the polarity input still applies. The settings are captured when a transfer starts and stay fixed until it ends. At the end of each byte the engine raises a one-cycle done pulse together with the received byte.

Top module: `ser_shift_engine`

## Requirements
- R1: While reset is asserted: `sclkOut` is 0, `csOutN` is 1, `done` is 0 and `rxByte` is 0.
- R2: In master mode `rateSel` code r (0..6) sets a half clock period of 2<<r system cycles, which is a divide-by 4, 8, ..., 256. Code 7 behaves like code 6. The first clock edge comes one half period after the cycle that accepts `start`, and `done` rises exactly 16 half periods after that cycle.
- R3: `sclkOe` equals 1 in master mode and 0 in slave mode. Outside a transfer `sclkOut` rests at `clkPol`. A master transfer makes exactly 16 clock edges.
- R4: With effective phase 0, the first data bit is on `sdo` in the first cycle of the frame. Data is captured on edges 1, 3, ..., 15 and changed on edges 2, 4, ..., 14.
- R5: With effective phase 1, data is changed on edges 3, 5, ..., 15 and captured on edges 2, 4, ..., 16. The first bit is already on `sdo` when the frame opens.
- R6: When `syncMode` is 1, `clkPha` is ignored and phase-0 timing is used, in both master and slave modes.
- R7: With `msbFirst` = 0 bit 0 goes first and bit 7 last. With `msbFirst` = 1 bit 7 goes first. Both directions apply to transmit and receive.
- R8: After the 16th edge, `done` is high for exactly one cycle with the received byte on `rxByte`. In master mode `csOutN` is 1 and `sclkOut` is back at `clkPol` in that same cycle.
- R9: Mode, polarity, phase, bit order and rate are taken when a transfer starts. Changes to these inputs during the transfer have no effect on it.
- R10: In slave mode a falling `csInN` (after a two-flop synchroniser) opens a frame. Sixteen edges on `sclkIn` (also synchronised, with a rate at most a quarter of the system clock) move a byte each way and produce `done`.
- R11: In slave mode, `csInN` returning high before the 16th edge ends the frame without `done`, and the next frame works normally.
- R12: `csOutN` goes low only during a master-mode transfer, from the cycle after `start` is accepted until the cycle `done` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| isMaster | input | 1 | 1 = generate the serial clock, 0 = accept an external one |
| rateSel | input | 3 | Master clock rate code |
| clkPol | input | 1 | Serial clock idle level |
| clkPha | input | 1 | 0 = capture on first edge, 1 = launch on first edge |
| syncMode | input | 1 | 1 = clock-synchronous mode, phase forced to 0 |
| msbFirst | input | 1 | Bit order: 1 = most significant bit first |
| start | input | 1 | Master-mode transfer request pulse |
| txByte | input | 8 | Byte to transmit |
| rxByte | output | 8 | Last byte received |
| done | output | 1 | One-cycle end-of-transfer pulse |
| sclkIn | input | 1 | External serial clock (slave mode) |
| csInN | input | 1 | External active-low chip select (slave mode) |
| sclkOut | output | 1 | Generated serial clock (master mode) |
| sclkOe | output | 1 | Output enable for the serial clock pin |
| csOutN | output | 1 | Active-low chip select driven in master mode |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |

## Verification
The bench plays the far end of the link in both roles and targets the places where phase and bit order meet. Phase 1 has a dead first edge. If that edge shifted, the first bit would be lost and every byte would arrive shifted by one. In clock-synchronous mode with the phase input at 1, a design that still obeyed the phase would capture on the wrong edges. The bench counts cycles from `start` to `done` at rate codes 0 through 7, which exposes an off-by-one divider or a code 7 that does not saturate. It toggles the settings in mid-transfer to show that a design which failed to hold them would corrupt the byte. It also drops chip select early in slave mode to catch a design that raises `done` for a truncated frame or stays stuck busy.

// File: rtl/sse_pkg.sv
package sse_pkg;
  localparam int RATE_W = 3;

  typedef struct packed {
    logic              master;
    logic              clkPol;
    logic              effPha;
    logic              msbFirst;
    logic [RATE_W-1:0] rate;
  } sse_cfg_t;

  typedef struct packed {
    logic load;
    logic launch;
    logic sample;
    logic finish;
  } sse_strobe_t;
endpackage

// File: rtl/sse_ctrl.sv
module sse_ctrl
  import sse_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int MAX_RATE       = 6,
  parameter int BASE_HALF_LOG2 = 1,
  parameter int SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              isMaster,
  input  logic [RATE_W-1:0] rateSel,
  input  logic              clkPol,
  input  logic              clkPha,
  input  logic              syncMode,
  input  logic              msbFirst,
  input  logic              start,
  input  logic              sclkIn,
  input  logic              csInN,
  output sse_cfg_t          cfgQ,
  output sse_strobe_t       stb,
  output logic              busy,
  output logic              sclkOut,
  output logic              csOutN
);
  localparam int CNT_W  = BASE_HALF_LOG2 + MAX_RATE;
  localparam int EDGE_W = $clog2(2 * DATA_W + 1);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * DATA_W);
  localparam logic [CNT_W-1:0]  CNT_ALL   = '1;
  localparam logic [RATE_W-1:0] RATE_CAP  = RATE_W'(MAX_RATE);

  // synchronisers for the slave-side clock and select
  logic [SYNC_STAGES-1:0] sclkSyn, csSyn;
  logic sclkS, csS, sclkPrev, csPrev;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclkSyn[gi] <= 1'b0;
          csSyn[gi]   <= 1'b1;
        end else begin
          sclkSyn[gi] <= (gi == 0) ? sclkIn : sclkSyn[(gi == 0) ? 0 : gi - 1];
          csSyn[gi]   <= (gi == 0) ? csInN  : csSyn[(gi == 0) ? 0 : gi - 1];
        end
      end
    end
  endgenerate

  assign sclkS = sclkSyn[SYNC_STAGES-1];
  assign csS   = csSyn[SYNC_STAGES-1];

  sse_cfg_t          cfgNext;
  logic [RATE_W-1:0] rateCap;
  logic [CNT_W-1:0]  halfLim, divCnt;
  logic [EDGE_W-1:0] edgeCnt, edgeNum;
  logic              lvl, go, abortFrame, tick, isSample, slaveEdge;

  always_comb begin
    cfgNext.master   = isMaster;
    cfgNext.clkPol   = clkPol;
    cfgNext.effPha   = syncMode ? 1'b0 : clkPha;
    cfgNext.msbFirst = msbFirst;
    cfgNext.rate     = rateSel;
  end

  always_comb begin
    rateCap = (cfgQ.rate > RATE_CAP) ? RATE_CAP : cfgQ.rate;
    halfLim = CNT_ALL >> (RATE_CAP - rateCap);
  end

  assign edgeNum    = edgeCnt + EDGE_W'(1);
  assign isSample   = edgeNum[0] ^ cfgQ.effPha;
  assign slaveEdge  = sclkS ^ sclkPrev;
  assign go         = !busy && (isMaster ? start : (csPrev && !csS));
  assign abortFrame = busy && !cfgQ.master && csS;
  assign tick       = busy && !abortFrame &&
                      (cfgQ.master ? (divCnt == halfLim) : slaveEdge);

  always_comb begin
    stb.load   = !busy;
    stb.sample = tick && isSample;
    stb.launch = tick && !isSample &&
                 (cfgQ.effPha ? (edgeNum != EDGE_W'(1)) : (edgeNum != LAST_EDGE));
    stb.finish = tick && (edgeNum == LAST_EDGE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      cfgQ     <= '0;
      divCnt   <= '0;
      edgeCnt  <= '0;
      lvl      <= 1'b0;
      sclkPrev <= 1'b0;
      csPrev   <= 1'b1;
    end else begin
      sclkPrev <= sclkS;
      csPrev   <= csS;
      if (!busy) begin
        cfgQ    <= cfgNext;
        divCnt  <= '0;
        edgeCnt <= '0;
        lvl     <= 1'b0;
        if (go) busy <= 1'b1;
      end else if (abortFrame) begin
        busy <= 1'b0;
      end else begin
        if (cfgQ.master) divCnt <= tick ? '0 : divCnt + CNT_W'(1);
        if (tick) begin
          edgeCnt <= edgeNum;
          if (cfgQ.master) lvl <= ~lvl;
          if (edgeNum == LAST_EDGE) busy <= 1'b0;
        end
      end
    end
  end

  assign sclkOut = cfgQ.clkPol ^ lvl;
  assign csOutN  = ~(busy & cfgQ.master);
endmodule

// File: rtl/sse_datapath.sv
module sse_datapath
  import sse_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  sse_strobe_t       stb,
  input  logic              useRawSdi,
  input  logic              msbOrder,
  input  logic [DATA_W-1:0] txByte,
  input  logic              sdi,
  output logic              sdo,
  output logic [DATA_W-1:0] rxByte,
  output logic              done
);
  logic [DATA_W-1:0]      txShift, rxShift, rxNext;
  logic [SYNC_STAGES-1:0] sdiSyn;
  logic                   sdiBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sdiSyn <= '0;
    else       sdiSyn <= {sdiSyn[SYNC_STAGES-2:0], sdi};
  end

  // slave data is delayed as much as the slave clock so both stay aligned
  assign sdiBit = useRawSdi ? sdi : sdiSyn[SYNC_STAGES-1];
  assign sdo    = msbOrder ? txShift[DATA_W-1] : txShift[0];

  always_comb begin
    rxNext = rxShift;
    if (stb.sample)
      rxNext = msbOrder ? {rxShift[DATA_W-2:0], sdiBit} : {sdiBit, rxShift[DATA_W-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rxByte  <= '0;
      done    <= 1'b0;
    end else begin
      if (stb.load)        txShift <= txByte;
      else if (stb.launch) txShift <= msbOrder ? {txShift[DATA_W-2:0], 1'b0}
                                               : {1'b0, txShift[DATA_W-1:1]};
      rxShift <= rxNext;
      if (stb.finish) rxByte <= rxNext;
      done <= stb.finish;
    end
  end
endmodule

// File: rtl/ser_shift_engine.sv
module ser_shift_engine
  import sse_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int MAX_RATE       = 6,
  parameter int BASE_HALF_LOG2 = 1,
  parameter int SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              isMaster,
  input  logic [2:0]        rateSel,
  input  logic              clkPol,
  input  logic              clkPha,
  input  logic              syncMode,
  input  logic              msbFirst,
  input  logic              start,
  input  logic [DATA_W-1:0] txByte,
  output logic [DATA_W-1:0] rxByte,
  output logic              done,
  input  logic              sclkIn,
  input  logic              csInN,
  output logic              sclkOut,
  output logic              sclkOe,
  output logic              csOutN,
  input  logic              sdi,
  output logic              sdo
);
  sse_cfg_t    cfgQ;
  sse_strobe_t stb;
  logic        busy;

  sse_ctrl #(
    .DATA_W(DATA_W), .MAX_RATE(MAX_RATE),
    .BASE_HALF_LOG2(BASE_HALF_LOG2), .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .isMaster(isMaster), .rateSel(rateSel),
    .clkPol(clkPol), .clkPha(clkPha), .syncMode(syncMode), .msbFirst(msbFirst),
    .start(start), .sclkIn(sclkIn), .csInN(csInN), .cfgQ(cfgQ), .stb(stb),
    .busy(busy), .sclkOut(sclkOut), .csOutN(csOutN)
  );

  sse_datapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .useRawSdi(cfgQ.master),
    .msbOrder(cfgQ.msbFirst), .txByte(txByte), .sdi(sdi), .sdo(sdo),
    .rxByte(rxByte), .done(done)
  );

  assign sclkOe = cfgQ.master;
endmodule

// File: rtl/sse_checker.sv
module sse_checker
  import sse_pkg::*;
(
  input logic     clk,
  input logic     rstN,
  input logic     sclkOut,
  input logic     csOutN,
  input logic     done,
  input logic     busy,
  input sse_cfg_t cfgHeld
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);                                               // R8
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && csOutN));                                   // R8
  AST_IDLE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sclkOut == cfgHeld.clkPol));                        // R3
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(cfgHeld));                   // R9
  AST_CS_MASTER_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !csOutN |-> (busy && cfgHeld.master));                         // R12
endmodule

bind ser_shift_engine sse_checker chk_i (
  .clk(clk), .rstN(rstN), .sclkOut(sclkOut), .csOutN(csOutN),
  .done(done), .busy(busy), .cfgHeld(cfgQ)
);

// File: tb/ser_shift_engine_tb_top.sv
`timescale 1ns/1ps
module ser_shift_engine_tb_top;
  logic clk = 1'b0, rstN = 1'b0;
  logic isMaster = 1'b1, clkPol = 1'b0, clkPha = 1'b0, syncMode = 1'b0, msbFirst = 1'b0;
  logic start = 1'b0, sclkIn = 1'b0, csInN = 1'b1, sdi = 1'b0;
  logic [2:0] rateSel = 3'd0;
  logic [7:0] txByte = 8'h00;
  logic [7:0] rxByte;
  logic done, sclkOut, sclkOe, csOutN, sdo;

  always #4 clk = ~clk;

  ser_shift_engine dut_i (
    .clk(clk), .rstN(rstN), .isMaster(isMaster), .rateSel(rateSel), .clkPol(clkPol),
    .clkPha(clkPha), .syncMode(syncMode), .msbFirst(msbFirst), .start(start),
    .txByte(txByte), .rxByte(rxByte), .done(done), .sclkIn(sclkIn), .csInN(csInN),
    .sclkOut(sclkOut), .sclkOe(sclkOe), .csOutN(csOutN), .sdi(sdi), .sdo(sdo)
  );

  int nChecks = 0, nFail = 0, doneCnt = 0;
  bit finished = 1'b0;
  logic [7:0] expQ[$];
  string tagQ[$];

  // external slave model state (master-mode tests)
  logic [7:0] slvByte = 8'h00, slvCap = 8'h00;
  bit mPha = 1'b0, mMsb = 1'b0;
  int sIdx = 0, dIdx = 0, mEdges = 0;

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  // monitor: pops expected bytes as done pulses appear
  initial begin
    logic [7:0] e;
    string t;
    forever begin
      @(negedge clk);
      if (rstN && done) begin
        doneCnt++;
        if (expQ.size() == 0) begin
          nChecks++; nFail++;
          $display("FAIL R11 unexpected done: actual=1 expected=0");
        end else begin
          e = expQ.pop_front();
          t = tagQ.pop_front();
          checkEq(t, "received byte", rxByte, e);
        end
      end
    end
  end

  // slave model: reacts to the generated clock while a master frame runs
  initial begin
    forever begin
      @(negedge csOutN);
      sIdx = 0; dIdx = 0; mEdges = 0; slvCap = 8'h00;
      sdi = slvByte[mMsb ? 7 : 0];
      for (int k = 1; k <= 16; k++) begin
        @(sclkOut);
        #1;
        mEdges++;
        if ((((k % 2) == 1) ? 1'b1 : 1'b0) ^ mPha) begin
          slvCap[mMsb ? 7 - sIdx : sIdx] = sdo;
          sIdx++;
        end else if (sIdx >= 1 && sIdx <= 7) begin
          dIdx++;
          sdi = slvByte[mMsb ? 7 - dIdx : dIdx];
        end
      end
    end
  end

  task automatic masterXfer(input logic [2:0] rate, input bit pol, input bit pha,
                            input bit syncM, input bit msb, input logic [7:0] tx,
                            input logic [7:0] sByte, input bit perturb, input string tag);
    int h, n;
    h = 2 << ((rate > 3'd6) ? 6 : int'(rate));
    isMaster = 1'b1; rateSel = rate; clkPol = pol; clkPha = pha;
    syncMode = syncM; msbFirst = msb; txByte = tx;
    slvByte = sByte; mPha = syncM ? 1'b0 : pha; mMsb = msb;
    repeat (3) @(negedge clk);
    checkEq("R3", "clock output enable in master mode", sclkOe, 1);
    checkEq("R3", "idle clock level", sclkOut, pol);
    expQ.push_back(sByte); tagQ.push_back(tag);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    checkEq("R12", "chip select after start", csOutN, 0);
    checkEq(mPha ? "R5" : "R4", "first bit on sdo at frame open", sdo, msb ? tx[7] : tx[0]);
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
      if (perturb && n == 5) begin
        clkPol = ~pol; clkPha = ~pha; msbFirst = ~msb; rateSel = ~rate; syncMode = ~syncM;
      end
      if (perturb && n == 12) begin
        clkPol = pol; clkPha = pha; msbFirst = msb; rateSel = rate; syncMode = syncM;
      end
    end
    checkEq("R2", "cycles from start to done", n, 16 * h + 1);
    checkEq("R8", "chip select released with done", csOutN, 1);
    checkEq("R8", "clock idle with done", sclkOut, pol);
    checkEq("R3", "clock edges in frame", mEdges, 16);
    checkEq(tag, "byte seen by external slave", slvCap, tx);
    repeat (2) @(negedge clk);
  endtask

  task automatic slaveXfer(input bit pol, input bit pha, input bit syncM, input bit msb,
                           input logic [7:0] tx, input logic [7:0] mByte,
                           input int abortAt, input string tag);
    int s, d, d0;
    bit ep;
    logic [7:0] cap;
    isMaster = 1'b0; clkPol = pol; clkPha = pha; syncMode = syncM; msbFirst = msb;
    txByte = tx; csInN = 1'b1; sclkIn = pol;
    repeat (4) @(negedge clk);
    checkEq("R3", "clock output enable in slave mode", sclkOe, 0);
    ep = syncM ? 1'b0 : pha;
    d0 = doneCnt;
    if (abortAt == 0) begin expQ.push_back(mByte); tagQ.push_back(tag); end
    s = 0; d = 0; cap = 8'h00;
    sdi = mByte[msb ? 7 : 0];
    csInN = 1'b0;
    repeat (8) @(negedge clk);
    for (int k = 1; k <= 16; k++) begin
      if (abortAt != 0 && k == abortAt) break;
      repeat (6) @(negedge clk);
      sclkIn = ~sclkIn;
      if ((((k % 2) == 1) ? 1'b1 : 1'b0) ^ ep) begin
        cap[msb ? 7 - s : s] = sdo;
        s++;
      end else if (s >= 1 && s <= 7) begin
        d++;
        sdi = mByte[msb ? 7 - d : d];
      end
    end
    repeat (8) @(negedge clk);
    checkEq("R12", "chip select output idle in slave mode", csOutN, 1);
    csInN = 1'b1; sclkIn = pol;
    repeat (6) @(negedge clk);
    if (abortAt == 0) begin
      checkEq(tag, "byte seen by external master", cap, tx);
      checkEq("R10", "one done per slave frame", doneCnt, d0 + 1);
    end else begin
      checkEq("R11", "no done after aborted frame", doneCnt, d0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL R2 watchdog expired: actual=running expected=finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    checkEq("R1", "clock in reset", sclkOut, 0);
    checkEq("R1", "chip select in reset", csOutN, 1);
    checkEq("R1", "done in reset", done, 0);
    checkEq("R1", "rx byte in reset", rxByte, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    masterXfer(3'd0, 0, 0, 0, 1, 8'hA5, 8'h3C, 0, "R7");
    masterXfer(3'd1, 1, 0, 0, 0, 8'h81, 8'h7E, 0, "R7");
    masterXfer(3'd2, 0, 1, 0, 1, 8'hC3, 8'h18, 0, "R5");
    masterXfer(3'd3, 1, 1, 0, 0, 8'h4B, 8'hD2, 0, "R5");
    masterXfer(3'd0, 1, 1, 1, 1, 8'h96, 8'hE1, 0, "R6");
    masterXfer(3'd0, 0, 1, 1, 0, 8'h2D, 8'hB4, 0, "R6");
    masterXfer(3'd4, 0, 0, 0, 1, 8'h11, 8'hEE, 0, "R4");
    masterXfer(3'd5, 1, 0, 0, 0, 8'h3E, 8'h61, 0, "R2");
    masterXfer(3'd6, 0, 0, 0, 1, 8'h5A, 8'hA5, 0, "R2");
    masterXfer(3'd7, 1, 0, 0, 0, 8'hF0, 8'h0F, 0, "R2");
    masterXfer(3'd2, 0, 0, 0, 1, 8'hC9, 8'h36, 1, "R9");

    slaveXfer(0, 0, 0, 1, 8'h6C, 8'h93, 0, "R10");
    slaveXfer(1, 1, 0, 0, 8'hB1, 8'h4E, 0, "R10");
    slaveXfer(0, 1, 1, 1, 8'hE7, 8'h19, 0, "R6");
    slaveXfer(0, 0, 0, 1, 8'h55, 8'hAA, 7, "R11");
    slaveXfer(0, 0, 0, 1, 8'h3A, 8'hC5, 0, "R11");

    checkEq("R8", "expected results left unmatched", expQ.size(), 0);
    report();
  end
endmodule